// File: doc/BRIEF.md
# MDIO Management-Frame Responder

This block sits on the PHY side of a management bus whose clock and data lines are driven by software toggling register bits. It watches the management clock level, and on every rising edge it takes one bit from the host data line. The bit counts as 1 only while the host drive enable is also high. Thirty-two sampled ones in a row put the block in step with the host. The next sixteen bits form a header that selects a read, a write or nothing.

A read returns one of thirty-two 16-bit registers on the reply line, most significant bit first, one bit per rising edge. A write stores the sixteen bits that follow the header. The register file comes out of reset with two identifier words loaded and every other entry cleared. Every PHY address is answered. The management clock is sampled by the system clock, so each rising edge is handled in the single system-clock cycle in which it is seen.

The frame state machine has three states:
- FR_IDLE: waiting.
- FR_FETCH: a read data phase.
- FR_STORE: a write data phase.

Its transitions are as follows:
- Header decode leaves FR_IDLE for FR_FETCH or FR_STORE. It can also re-enter from either busy state when a new sync arrives.
- End-of-frame returns FR_FETCH or FR_STORE to FR_IDLE on the sixteenth data edge.
- A rejected header returns to FR_IDLE.
- Reset forces FR_IDLE from any state.

Top module: `mdio_slave_decoder`

## Requirements
- R1: A synchronous active-high `rst` drives `mdio_reply` to 0, abandons any frame in progress and reloads the register file. After reset, register 2 holds 0x0022, register 3 holds 0x161A and all other registers hold 0.
- R2: Only a rising edge of `mdc_in` advances the block. A rising edge is a cycle in which `mdc_in` is high after being low in the previous cycle. Changes on `mdio_host` or `mdio_host_en` at any other time have no effect.
- R3: The sampled bit is the AND of `mdio_host` and `mdio_host_en`. A high `mdio_host` with the enable low is sampled as 0.
- R4: Thirty-two consecutive sampled ones synchronise the block. The next 16 sampled bits form the header, with the first bit received as bit 15. The header fields are: start in bits 15:14, opcode in bits 13:12, PHY address in bits 11:7, register address in bits 6:2 and turnaround in bits 1:0.
- R5: A header with start 01, opcode 10 and turnaround bit 0 equal to 0 is a read. On each of the next 16 rising edges, `mdio_reply` takes the next bit of the addressed register, MSB first. It changes in the clock cycle that follows the edge-detect cycle.
- R6: A header with start 01, opcode 01 and turnaround 10 is a write. The next 16 sampled bits, MSB first, are stored in the addressed register when the last of them arrives.
- R7: Any other header is rejected. No register changes and `mdio_reply` keeps its value.
- R8: The PHY address field is not compared. Frames carrying any PHY address are answered.
- R9: Once a frame ends, no further header is decoded until a new run of 32 ones arrives, however many edges follow.
- R10: `mdio_reply` changes only during a read data phase. At all other times it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the management lines |
| rst | input | 1 | Synchronous reset, active high |
| mdc_in | input | 1 | Management clock level as driven by the host |
| mdio_host | input | 1 | Serial data level driven by the host |
| mdio_host_en | input | 1 | Host drive enable; a sampled bit is 1 only while it is high |
| mdio_reply | output | 1 | Serial data returned to the host during a read |

## Verification
A wrong bit count or a missed sync shows at the ports only in the data phase of the frame it disturbs. A read header decoded one edge early or late produces a reply stream shifted by one bit on the very next edge. A wrong decode state or header window appears either as a register that changed when it should not have, or as one that kept its old value. That is visible only on the next read of that register, up to one full frame later. The bench therefore runs a reference model on every clock cycle, which catches a wrong reply bit in the cycle it appears. Every write is read back before the test moves on.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int SYNC_LEN  = 32;
    localparam int CNT_W     = $clog2(SYNC_LEN + 1);

    // header field positions (first received bit is bit DATA_W-1)
    localparam int START_LSB = 14;
    localparam int OP_LSB    = 12;
    localparam int REG_LSB   = 2;

    localparam logic [1:0] START_MARK = 2'b01;
    localparam logic [1:0] OP_STORE   = 2'b01;
    localparam logic [1:0] OP_FETCH   = 2'b10;
    localparam logic [1:0] TA_STORE   = 2'b10;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_FETCH = 2'd1,
        FR_STORE = 2'd2
    } frame_state_e;

endpackage

// File: rtl/mdio_edge_detect.sv
module mdio_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic mdc,
    output logic rise
);

    logic mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q <= 1'b0;
        end else begin
            mdc_q <= mdc;
        end
    end

    assign rise = mdc & ~mdc_q;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_slave_pkg::*;
#(
    parameter int             ID_IDX_A = 2,
    parameter logic [DATA_W-1:0] ID_VAL_A = 16'h0022,
    parameter int             ID_IDX_B = 3,
    parameter logic [DATA_W-1:0] ID_VAL_B = 16'h161A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
        localparam logic [DATA_W-1:0] INIT_VAL =
            (gi == ID_IDX_A) ? ID_VAL_A :
            (gi == ID_IDX_B) ? ID_VAL_B : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[gi] <= INIT_VAL;
            end else if (we && (waddr == ADDR_W'(gi))) begin
                regs_q[gi] <= wdata;
            end
        end
    end

    assign rdata = regs_q[raddr];

    // R6: a store request lands in the addressed entry
    assert_store_lands_R6: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              host_data,
    input  logic              host_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              reply
);

    logic [SYNC_LEN-1:0] shift_q, shift_nx;
    logic [CNT_W-1:0]    cnt_q, cnt_eff;
    frame_state_e        state_q, state_nx, decoded;
    logic [ADDR_W-1:0]   reg_q;
    logic [DATA_W-1:0]   dout_q;
    logic                reply_q;
    logic                at_hdr, at_end, in_data;
    logic [1:0]          start_f, op_f, ta_f;

    // window and counter as seen by the current edge
    always_comb begin
        shift_nx = {shift_q[SYNC_LEN-2:0], host_data & host_en};
        cnt_eff  = (&shift_nx) ? CNT_W'(SYNC_LEN) : cnt_q;
        at_hdr   = (cnt_eff == CNT_W'(DATA_W));
        at_end   = (cnt_eff == '0);
        in_data  = (cnt_eff < CNT_W'(DATA_W));
        start_f  = shift_nx[START_LSB +: 2];
        op_f     = shift_nx[OP_LSB +: 2];
        ta_f     = shift_nx[1:0];
        if (start_f == START_MARK && op_f == OP_STORE && ta_f == TA_STORE) begin
            decoded = FR_STORE;
        end else if (start_f == START_MARK && op_f == OP_FETCH && !ta_f[0]) begin
            decoded = FR_FETCH;
        end else begin
            decoded = FR_IDLE;
        end
    end

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (rise && at_hdr) state_nx = decoded;
            end
            FR_FETCH, FR_STORE: begin
                if (rise) begin
                    if (at_hdr)      state_nx = decoded;
                    else if (at_end) state_nx = FR_IDLE;
                end
            end
            default: state_nx = FR_IDLE;
        endcase
    end

    // state register with shift window, bit counter and latched address
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            shift_q <= '0;
            cnt_q   <= '0;
            reg_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (rise) begin
                shift_q <= shift_nx;
                cnt_q   <= at_end ? '0 : cnt_eff - 1'b1;
                if (at_hdr) reg_q <= shift_nx[REG_LSB +: ADDR_W];
            end
        end
    end

    // serial reply output
    always_ff @(posedge clk) begin
        if (rst) begin
            reply_q <= 1'b0;
            dout_q  <= '0;
        end else if (rise) begin
            if (at_hdr && decoded == FR_FETCH) begin
                dout_q <= rd_data;
            end else if (state_q == FR_FETCH && in_data) begin
                reply_q <= dout_q[DATA_W-1];
                dout_q  <= {dout_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rd_addr = shift_nx[REG_LSB +: ADDR_W];
    assign wr_en   = rise && (state_q == FR_STORE) && at_end;
    assign wr_addr = reg_q;
    assign wr_data = shift_nx[DATA_W-1:0];
    assign reply   = reply_q;

    // R2: nothing advances without a rising management edge
    assert_quiet_between_edges_R2: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(shift_q) && $stable(cnt_q) && $stable(state_q)));

    // R4: a data phase opens only right after the sixteenth header edge
    assert_frame_opens_at_header_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q != FR_IDLE && $past(state_q) == FR_IDLE) |-> (cnt_q == CNT_W'(DATA_W - 1)));

    // R4: the bit counter never exceeds the sync length
    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(SYNC_LEN));

endmodule

// File: rtl/mdio_slave_decoder.sv
module mdio_slave_decoder
    import mdio_slave_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_WORD_HI = 16'h0022,
    parameter logic [DATA_W-1:0] ID_WORD_LO = 16'h161A
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_in,
    input  logic mdio_host,
    input  logic mdio_host_en,
    output logic mdio_reply
);

    logic              rise;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    mdio_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .mdc  (mdc_in),
        .rise (rise)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .host_data (mdio_host),
        .host_en   (mdio_host_en),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reply     (mdio_reply)
    );

    mdio_regfile #(
        .ID_IDX_A (2),
        .ID_VAL_A (ID_WORD_HI),
        .ID_IDX_B (3),
        .ID_VAL_B (ID_WORD_LO)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R10: the reply line moves only on a management edge
    assert_reply_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(mdio_reply));

endmodule

// File: tb/mdio_slave_decoder_test.sv
module mdio_slave_decoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mdc_in = 1'b0;
    logic mdio_host = 1'b0;
    logic mdio_host_en = 1'b0;
    logic mdio_reply;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";
    bit    done    = 1'b0;

    always #4 clk = ~clk;

    mdio_slave_decoder uut (
        .clk          (clk),
        .rst          (rst),
        .mdc_in       (mdc_in),
        .mdio_host    (mdio_host),
        .mdio_host_en (mdio_host_en),
        .mdio_reply   (mdio_reply)
    );

    // ---------------- behavioural reference model ----------------
    logic        m_prev, m_reply, m_bit;
    logic [31:0] m_hist;
    int          m_cnt, m_mode, m_addr;
    logic [15:0] m_out;
    logic [15:0] m_regs [32];

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_reply = 0; m_hist = 0; m_cnt = 0; m_mode = 0;
            m_addr = 0; m_out = 0;
            for (int i = 0; i < 32; i++) m_regs[i] = 16'h0000;
            m_regs[2] = 16'h0022;
            m_regs[3] = 16'h161A;
        end else begin
            if (mdc_in && !m_prev) begin
                m_bit  = mdio_host & mdio_host_en;
                m_hist = {m_hist[30:0], m_bit};
                if (m_hist == 32'hFFFF_FFFF) m_cnt = 32;
                if (m_cnt == 16) begin
                    if (m_hist[15:12] == 4'b0101 && m_hist[1:0] == 2'b10) m_mode = 2;
                    else if (m_hist[15:12] == 4'b0110 && !m_hist[0]) m_mode = 1;
                    else m_mode = 0;
                    m_addr = int'(m_hist[6:2]);
                    if (m_mode == 1) m_out = m_regs[m_addr];
                end
                if (m_cnt < 16 && m_mode == 1) begin
                    m_reply = m_out[15];
                    m_out   = m_out << 1;
                end
                if (m_cnt == 0 && m_mode != 0) begin
                    if (m_mode == 2) m_regs[m_addr] = m_hist[15:0];
                    m_mode = 0;
                end
                m_cnt = m_cnt - 1;
            end
            m_prev = mdc_in;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_tests++;
            if (mdio_reply !== m_reply) begin
                n_fail++;
                $display("FAIL %s per-cycle reply: actual %b expected %b at %0t",
                         cur_tag, mdio_reply, m_reply, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mdc_in = 1'b0; mdio_host = 1'b0; mdio_host_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic mdc_bit(input logic b, input logic en, input logic noisy);
        @(negedge clk);
        mdio_host = b; mdio_host_en = en; mdc_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        mdc_in = 1'b1;
        @(negedge clk);
        if (noisy) begin mdio_host = ~b; mdio_host_en = ~en; end
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input logic en, input logic noisy);
        for (int i = n - 1; i >= 0; i--) mdc_bit(v[i], en, noisy);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] d, input logic noisy);
        send_bits(32'hFFFF_FFFF, 32, 1'b1, noisy);
        send_bits({16'h0, 2'b01, 2'b01, phy, ra, 2'b10}, 16, 1'b1, noisy);
        send_bits({16'h0, d}, 16, 1'b1, noisy);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                           input logic bad_ta, output logic [15:0] got);
        send_bits(32'hFFFF_FFFF, 32, 1'b1, 1'b0);
        send_bits({18'h0, 2'b01, 2'b10, phy, ra}, 14, 1'b1, 1'b0);
        if (bad_ta) begin mdc_bit(1'b1, 1'b1, 1'b0); mdc_bit(1'b1, 1'b1, 1'b0); end
        else        begin mdc_bit(1'b0, 1'b0, 1'b0); mdc_bit(1'b0, 1'b0, 1'b0); end
        got = '0;
        for (int k = 0; k < 16; k++) begin
            mdc_bit(1'b0, 1'b0, 1'b0);
            got = {got[14:0], mdio_reply};
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rd;
        logic        prev;

        do_reset();
        @(negedge clk);
        check16("R1 reply after reset", {15'h0, mdio_reply}, 16'h0000);

        cur_tag = "R5";
        do_read(5'd0, 5'd2, 1'b0, rd);  check16("R1 R5 id word reg2", rd, 16'h0022);
        do_read(5'd9, 5'd3, 1'b0, rd);  check16("R1 R5 id word reg3", rd, 16'h161A);
        do_read(5'd0, 5'd0, 1'b0, rd);  check16("R1 reg0 cleared", rd, 16'h0000);

        cur_tag = "R6";
        do_write(5'd7, 5'd5, 16'hA5C3, 1'b0);
        do_read(5'd19, 5'd5, 1'b0, rd); check16("R6 R8 write/read other phy", rd, 16'hA5C3);
        do_write(5'd31, 5'd31, 16'h8001, 1'b0);
        do_read(5'd0, 5'd31, 1'b0, rd); check16("R6 top register", rd, 16'h8001);

        cur_tag = "R10";
        do_write(5'd0, 5'd4, 16'h0000, 1'b0);
        check16("R10 reply held through write", {15'h0, mdio_reply}, 16'h0001);

        cur_tag = "R2";
        do_write(5'd3, 5'd10, 16'h3C96, 1'b1);
        do_read(5'd0, 5'd10, 1'b0, rd); check16("R2 noise while clock high", rd, 16'h3C96);

        cur_tag = "R3";
        send_bits(32'hFFFF_FFFF, 32, 1'b0, 1'b0);
        send_bits({16'h0, 2'b01, 2'b01, 5'd0, 5'd6, 2'b10}, 16, 1'b1, 1'b0);
        send_bits({16'h0, 16'h1234}, 16, 1'b1, 1'b0);
        do_read(5'd0, 5'd6, 1'b0, rd);  check16("R3 disabled preamble ignored", rd, 16'h0000);

        cur_tag = "R7";
        send_bits(32'hFFFF_FFFF, 32, 1'b1, 1'b0);
        send_bits({16'h0, 2'b01, 2'b00, 5'd0, 5'd5, 2'b10}, 16, 1'b1, 1'b0);
        send_bits({16'h0, 16'hFFFF}, 16, 1'b1, 1'b0);
        send_bits(32'hFFFF_FFFF, 32, 1'b1, 1'b0);
        send_bits({16'h0, 2'b01, 2'b01, 5'd0, 5'd5, 2'b11}, 16, 1'b1, 1'b0);
        send_bits({16'h0, 16'h0000}, 16, 1'b1, 1'b0);
        do_read(5'd0, 5'd5, 1'b0, rd);  check16("R7 bad opcode/turnaround no store", rd, 16'hA5C3);
        prev = mdio_reply;
        do_read(5'd0, 5'd2, 1'b1, rd);  check16("R7 bad read turnaround reply held", rd, {16{prev}});

        cur_tag = "R9";
        do_write(5'd0, 5'd5, 16'h0F0F, 1'b0);
        send_bits(32'h0, 32, 1'b1, 1'b0);
        send_bits({16'h0, 2'b01, 2'b01, 5'd0, 5'd9, 2'b10}, 16, 1'b1, 1'b0);
        send_bits({16'h0, 16'hBEEF}, 16, 1'b1, 1'b0);
        do_read(5'd0, 5'd9, 1'b0, rd);  check16("R9 no decode without sync", rd, 16'h0000);
        do_read(5'd0, 5'd5, 1'b0, rd);  check16("R9 R6 prior write kept", rd, 16'h0F0F);

        cur_tag = "R1";
        send_bits(32'hFFFF_FFFF, 32, 1'b1, 1'b0);
        send_bits({16'h0, 2'b01, 2'b01, 5'd0, 5'd12, 2'b10}, 16, 1'b1, 1'b0);
        send_bits({24'h0, 8'hC7}, 8, 1'b1, 1'b0);
        do_reset();
        send_bits({24'h0, 8'h3B}, 8, 1'b1, 1'b0);
        do_read(5'd0, 5'd12, 1'b0, rd); check16("R1 reset aborts frame", rd, 16'h0000);
        do_read(5'd0, 5'd5, 1'b0, rd);  check16("R1 reset clears written reg", rd, 16'h0000);
        do_read(5'd0, 5'd2, 1'b0, rd);  check16("R1 reset reloads id word", rd, 16'h0022);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule